// File: doc/BRIEF.md
# Two-Instruction Fetch-Execute Processor

This block is a small multi-cycle processor core. It executes two 32-bit register instructions: a three-register add and an indirect jump through a register. While the core waits in its idle state, a loader port writes a program into a byte-wide memory, one byte per cycle. A start pulse then releases the core. The start pulse also places a return address, supplied on an input, into register 31.

Each instruction is built from four single-byte reads into an instruction register. The program counter then advances by four, and the instruction executes against a 32-entry register file. A jump whose target equals the return address hands control back to the environment: the core raises `done` and stops. Any other encoding raises `illegal` and stops. A debug read port shows any register, so the environment can inspect the results.

Top module: `fetch_exec_core`

## Requirements
- R1: After reset, `pc` is 0, `done` and `illegal` are low, the core is idle, and every register reads 0.
- R2: The loader port writes `ld_byte` to address `ld_addr` only while the core is idle. Writes made after `start` has been accepted leave memory unchanged.
- R3: A `start` pulse in idle sets `pc` to 0 and loads `ret_addr` into register 31. Fetching then begins.
- R4: A fetch reads the bytes at pc, pc+1, pc+2 and pc+3. The byte at pc becomes instruction bits 31:24, and pc+3 becomes bits 7:0.
- R5: Each instruction takes six cycles: four fetch cycles, one increment cycle and one execute cycle. `pc` rises by 4 in the increment cycle, before execute.
- R6: The add encoding has bits 31:26 = 0, first source in 25:21, second source in 20:16, destination in 15:11, bits 10:6 = 0 and bits 5:0 = 0x20. It writes the sum of the two sources, modulo 2^32, to the destination.
- R7: Register 0 always reads 0. An add that targets register 0 changes nothing.
- R8: The jump encoding has bits 31:26 = 0, the target register in 25:21, bits 20:6 = 0 and bits 5:0 = 0x08. It sets `pc` to the value of the target register, and execution continues there.
- R9: When a jump sets `pc` equal to the return address captured at start, `done` rises and stays high. No further instruction runs, and `pc` holds.
- R10: Any other encoding sets `illegal`, which stays high. It writes no register and halts the core with `pc` already advanced past the bad word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Loader byte write enable (idle only) |
| ld_addr | input | AW | Loader byte address |
| ld_byte | input | 8 | Loader byte data |
| ret_addr | input | 32 | Return address loaded into register 31 at start |
| start | input | 1 | Release the core from idle |
| pc | output | 32 | Program counter |
| done | output | 1 | Run ended by a jump to the return address |
| illegal | output | 1 | Unsupported encoding seen |
| dbg_sel | input | 5 | Debug register select |
| dbg_data | output | 32 | Value of the selected register |

## Verification
Some properties are checked on every cycle: both halt flags are sticky and never high together, `pc` is frozen once the core halts, `pc` is 0 right after start, and `pc` rises by exactly four in each increment cycle. Other behaviour can only be shown by the bench's programs. These programs cover big-endian assembly, the add result including wraparound, the register-0 discard, a jump that continues elsewhere, the six-cycle cost of each instruction, loader writes ignored during a run, and illegal words with stray nonzero fields.

// File: rtl/fetch_exec_core.sv
module fetch_exec_core #(
  parameter int MEM_BYTES = 256,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_byte,
  input  logic [31:0]   ret_addr,
  input  logic          start,
  output logic [31:0]   pc,
  output logic          done,
  output logic          illegal,
  input  logic [4:0]    dbg_sel,
  output logic [31:0]   dbg_data
);
  localparam logic [2:0] S_IDLE = 3'd0, S_FETCH = 3'd1, S_INCR = 3'd2,
                         S_EXEC = 3'd3, S_HALT = 3'd4;

  logic [7:0]  mem [MEM_BYTES];
  logic [31:0] rf  [32];
  logic [2:0]  st;
  logic [1:0]  cnt;
  logic [31:0] ir, sentinel;

  wire [4:0]    rs = ir[25:21];
  wire [4:0]    rt = ir[20:16];
  wire [4:0]    rd = ir[15:11];
  wire [31:0]   va = rf[rs];
  wire [31:0]   vb = rf[rt];
  wire          is_add = ir[31:26] == 6'd0 && ir[10:6] == 5'd0 && ir[5:0] == 6'h20;
  wire          is_jr  = ir[31:26] == 6'd0 && ir[20:6] == 15'd0 && ir[5:0] == 6'h08;
  wire [AW-1:0] faddr = pc[AW-1:0] + AW'(cnt);

  assign dbg_data = rf[dbg_sel];

  always_ff @(posedge clk)
    if (st == S_IDLE && ld_we) mem[ld_addr] <= ld_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ir       <= '0;
      pc       <= '0;
      sentinel <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pc       <= '0;
          rf[31]   <= ret_addr;
          sentinel <= ret_addr;
          cnt      <= '0;
          st       <= S_FETCH;
        end
        S_FETCH: begin
          ir  <= {ir[23:0], mem[faddr]};
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) st <= S_INCR;
        end
        S_INCR: begin
          pc <= pc + 32'd4;
          st <= S_EXEC;
        end
        S_EXEC: begin
          if (is_add) begin
            if (rd != 5'd0) rf[rd] <= va + vb;
            st <= S_FETCH;
          end else if (is_jr) begin
            pc <= va;
            if (va == sentinel) begin
              done <= 1'b1;
              st   <= S_HALT;
            end else st <= S_FETCH;
          end else begin
            illegal <= 1'b1;
            st      <= S_HALT;
          end
        end
        default: st <= S_HALT;
      endcase
    end
  end
endmodule

module fetch_exec_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  st,
  input logic        start,
  input logic [31:0] pc,
  input logic        done,
  input logic        illegal
);
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n) done |=> done);
  a_r10_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n) illegal |=> illegal);
  a_r9_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(done && illegal));
  a_r9_halt_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n) (done || illegal) |=> $stable(pc));
  a_r3_pc_zero: assert property (@(posedge clk) disable iff (!rst_n) (st == 3'd0 && start) |=> pc == 32'd0);
  a_r5_pc_step: assert property (@(posedge clk) disable iff (!rst_n) (st == 3'd2) |=> pc == $past(pc) + 32'd4);
endmodule

bind fetch_exec_core fetch_exec_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .start(start),
  .pc(pc), .done(done), .illegal(illegal)
);

// File: tb/test_fetch_exec_core.sv
module test_fetch_exec_core;
  localparam int AW = 8;
  localparam logic [31:0] SENT = 32'h8000_0018;

  logic clk = 0, rst_n = 0, ld_we = 0, start = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_byte = '0;
  logic [31:0] ret_addr = SENT;
  logic [4:0] dbg_sel = '0;
  logic [31:0] pc, dbg_data;
  logic done, illegal;

  int tests = 0, fails = 0, cyc;
  bit finished = 0;

  typedef struct { string req; int idx; logic [31:0] val; } item_t;
  item_t sb_q[$];

  fetch_exec_core #(.MEM_BYTES(256)) i_fetch_exec_core (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_byte(ld_byte),
    .ret_addr(ret_addr), .start(start), .pc(pc), .done(done), .illegal(illegal),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data));

  always #10 clk = ~clk;

  function automatic logic [31:0] enc_add(int d, int s, int t);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] enc_jr(int s);
    return {6'd0, 5'(s), 15'd0, 6'h08};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(string req, int idx, logic [31:0] v);
    sb_q.push_back('{req, idx, v});
  endtask

  task automatic drain();
    while (sb_q.size() > 0) begin
      item_t it = sb_q.pop_front();
      @(negedge clk);
      dbg_sel = 5'(it.idx);
      #1 check(it.req, dbg_data, it.val);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic load_word(int a, logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      ld_we = 1; ld_addr = AW'(a + b); ld_byte = w[31-8*b -: 8];
    end
    @(negedge clk); ld_we = 0;
  endtask

  task automatic run();
    @(negedge clk); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    cyc = 0;
    while (!(done || illegal) && cyc < 2000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check("R1 pc", pc, 0);
    check("R1 done", {31'd0, done}, 0);
    check("R1 illegal", {31'd0, illegal}, 0);
    push("R1 reg5", 5, 0);
    drain();

    // program 1: add, jump elsewhere, add, add to r0, return
    load_word(0, enc_add(1, 31, 31));
    load_word(4, enc_jr(1));
    load_word(8, 32'hFFFF_FFFF);
    load_word(8'h30, enc_add(2, 1, 31));
    load_word(8'h34, enc_add(0, 1, 1));
    load_word(8'h38, enc_jr(31));
    run();
    check("R5 cycles for five instructions", cyc, 30);
    check("R9 done", {31'd0, done}, 1);
    check("R8 no illegal on skipped word", {31'd0, illegal}, 0);
    check("R9 pc at return address", pc, SENT);
    repeat (5) @(negedge clk);
    check("R9 pc holds after done", pc, SENT);
    push("R3 r31 return address", 31, SENT);
    push("R4 R6 add wraps", 1, 32'h0000_0030);
    push("R8 add at jump target", 2, 32'h8000_0048);
    push("R7 r0 stays zero", 0, 0);
    drain();

    // program 2: add with nonzero bits 10:6
    do_reset();
    load_word(0, enc_add(1, 31, 31));
    load_word(4, enc_add(2, 1, 1) | 32'h40);
    run();
    check("R10 illegal set", {31'd0, illegal}, 1);
    check("R10 done low", {31'd0, done}, 0);
    check("R5 R10 pc advanced past bad word", pc, 8);
    repeat (4) @(negedge clk);
    check("R10 halted pc", pc, 8);
    push("R10 no write from bad word", 2, 0);
    push("R6 first add done", 1, 32'h30);
    drain();

    // program 3: loader write during run ignored
    do_reset();
    load_word(0, enc_add(3, 31, 31));
    load_word(4, enc_jr(31));
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    ld_we = 1; ld_addr = 8'd7; ld_byte = 8'hFF;
    @(negedge clk); ld_addr = 8'd4;
    @(negedge clk); ld_we = 0;
    cyc = 0;
    while (!(done || illegal) && cyc < 2000) begin @(negedge clk); cyc++; end
    check("R2 runtime write ignored done", {31'd0, done}, 1);
    check("R2 runtime write ignored illegal", {31'd0, illegal}, 0);
    push("R2 add ran", 3, 32'h30);
    drain();

    // program 4: jump with nonzero bits 20:16
    do_reset();
    load_word(0, enc_jr(31) | 32'h0001_0000);
    run();
    check("R10 jump with stray field illegal", {31'd0, illegal}, 1);
    check("R10 pc after bad jump", pc, 4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule